// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a small serial memory that sits on a two-wire bus as a slave. A system clock samples SCL and SDA, and the engine finds start and stop conditions on the sampled lines. It collects an eight-bit device address, compares it with a three-bit strap value and acknowledges by pulling SDA low. It then runs a write transaction or a read transaction. The block never drives SDA high: `sda_oe` asks a pad outside the block to pull the line low.

In a write, the first byte after the address is handed to the array as a word address (`addr_load`). Each byte after that is handed over as data (`data_strobe`). The stop condition that closes a write with at least one data byte raises `commit` if the write grant from outside is high, and this starts a programming interval of `BUSY_CYCLES` clocks. During that interval the engine ignores the bus completely, so a master can poll with address bytes until one is acknowledged. In a read, the engine takes a byte from `rd_data` at the start of each byte, pulses `rd_next` so the array can move to the next byte, and shifts the byte out MSB first. A second family code marks protection commands, and `prot_cmd` reports it to the logic outside.

The states are IDLE, DEVADDR, WORDADDR, WDATA, ACK, RDATA, RACK and IGNORE. The transitions are as follows:
- A start from any state goes to DEVADDR.
- A stop from any state goes to IDLE.
- A matching address goes DEVADDR to ACK. A non-matching address goes DEVADDR to IGNORE.
- A complete byte goes WORDADDR or WDATA to ACK.
- At the end of the ninth pulse, ACK goes to the state chosen by the byte it acknowledged: WORDADDR, WDATA or RDATA.
- After eight bits, RDATA goes to RACK.
- A master acknowledge goes RACK to RDATA. A master no-acknowledge goes RACK to IGNORE.
- While the programming interval runs, the engine is held in IDLE.

Top module: `eeslv_engine`

## Requirements
- R1: After a start (SDA falling while SCL is high), the engine receives a device address from any state. After a stop (SDA rising while SCL is high), it ends the transfer and releases SDA.
- R2: An address byte is accepted when bits 7..4 are 1010 (memory) or 0110 (protection), bits 3..1 equal `strap[2:0]`, and bit 0 gives the direction (1 read, 0 write). When the byte is accepted, `sda_oe` is high during the ninth SCL pulse.
- R3: After an address byte that is not accepted, SDA stays released, and no acknowledge or strobe occurs until the next start.
- R4: In a write, the first byte after the address is acknowledged and gives one `addr_load` pulse with that byte on `addr_byte`.
- R5: Every later byte of the write is acknowledged and gives one `data_strobe` pulse with that byte on `data_byte`, in bus order.
- R6: A stop that closes a write with at least one data byte gives exactly one `commit` pulse when `wr_grant` is high. There is no pulse when there was no data byte or when `wr_grant` is low.
- R7: After `commit`, `busy` stays high for `BUSY_CYCLES` clocks. During that time no address is acknowledged and no strobe is produced. After it ends, a write address is acknowledged again.
- R8: In a read, each byte is taken from `rd_data` with one `rd_next` pulse and is sent MSB first. SDA changes only while SCL is low. A master acknowledge continues with the next byte. A master no-acknowledge releases SDA.
- R9: A start in the middle of a byte aborts that byte without any strobe, and a new address is received.
- R10: `prot_cmd` is high from the acknowledge of a protection-family address until the next start or stop, and low for memory-family transfers.
- R11: During reset and right after it, `sda_oe`, `busy`, `commit`, `addr_load`, `data_strobe` and `prot_cmd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Device-select straps, compared with address bits 3..1 |
| wr_grant | input | 1 | Write permission from outside, sampled at the stop |
| rd_data | input | 8 | Byte to send, taken at the start of each read byte |
| sda_oe | output | 1 | High asks the pad to pull SDA low |
| addr_load | output | 1 | One-clock pulse: word address is on addr_byte |
| addr_byte | output | 8 | Received word address |
| data_strobe | output | 1 | One-clock pulse: data byte is on data_byte |
| data_byte | output | 8 | Received data byte |
| commit | output | 1 | One-clock pulse that starts a programming interval |
| rd_next | output | 1 | One-clock pulse when a read byte has been taken |
| prot_cmd | output | 1 | Current transfer uses the protection family |
| busy | output | 1 | Programming interval in progress |

## Verification
The engine is driven with single-byte writes, multi-byte writes, a write with the grant withheld, a read of two bytes closed by a no-acknowledge, and a protection-family address. These cases tell apart the word-address strobe from the data strobes, committing from not committing, and the two address families. Address bytes with a wrong strap value and with a wrong family show whether the comparison covers both fields. An address poll right after a commit and a second poll after the interval show whether the engine is deaf for the whole interval and answers again after it. A start inserted three bits into a byte shows that a partial byte leaves no trace and that the engine recovers.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;

    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int BIT_CW  = $clog2(BYTE_W + 1);

    localparam logic [3:0] FAM_MEM  = 4'b1010;
    localparam logic [3:0] FAM_PROT = 4'b0110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_WORDADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } eng_state_e;

endpackage

// File: rtl/eeslv_line_sync.sv
module eeslv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    assign raw = {scl_in, sda_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s && !scl_q;
    assign scl_fall  = !scl_s &&  scl_q;
    assign start_det =  scl_s &&  scl_q &&  sda_q && !sda_s;
    assign stop_det  =  scl_s &&  scl_q && !sda_q &&  sda_s;

endmodule

// File: rtl/eeslv_busy_timer.sv
module eeslv_busy_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (kick)        cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/eeslv_engine.sv
module eeslv_engine
    import eeslv_pkg::*;
#(
    parameter int BUSY_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_grant,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               addr_load,
    output logic [BYTE_W-1:0]  addr_byte,
    output logic               data_strobe,
    output logic [BYTE_W-1:0]  data_byte,
    output logic               commit,
    output logic               rd_next,
    output logic               prot_cmd,
    output logic               busy
);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    eeslv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeslv_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (commit),
        .busy  (busy)
    );

    eng_state_e         state_q, state_d, ret_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic [BIT_CW-1:0]  bitcnt_q;
    logic               wrote_q;
    logic               mack_q;
    logic               byte_full;
    logic               dev_match;
    logic               fam_ok;

    assign byte_full = (bitcnt_q == BIT_CW'(BYTE_W));
    assign fam_ok    = (shreg_q[7:4] == FAM_MEM) || (shreg_q[7:4] == FAM_PROT);
    assign dev_match = fam_ok && (shreg_q[3:1] == strap);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEVADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_DEVADDR:
                    if (scl_fall && byte_full) state_d = dev_match ? ST_ACK : ST_IGNORE;
                ST_WORDADDR, ST_WDATA:
                    if (scl_fall && byte_full) state_d = ST_ACK;
                ST_ACK:
                    if (scl_fall) state_d = ret_q;
                ST_RDATA:
                    if (scl_fall && byte_full) state_d = ST_RACK;
                ST_RACK:
                    if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            ret_q    <= ST_IDLE;
            wrote_q  <= 1'b0;
            mack_q   <= 1'b0;
            prot_cmd <= 1'b0;
        end else if (busy || start_det || stop_det) begin
            bitcnt_q <= '0;
            wrote_q  <= 1'b0;
            mack_q   <= 1'b0;
            prot_cmd <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DEVADDR, ST_WORDADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        bitcnt_q <= '0;
                        if (state_q == ST_DEVADDR) begin
                            ret_q    <= shreg_q[0] ? ST_RDATA : ST_WORDADDR;
                            prot_cmd <= dev_match && (shreg_q[7:4] == FAM_PROT);
                        end else begin
                            ret_q <= ST_WDATA;
                            if (state_q == ST_WDATA) wrote_q <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall && ret_q == ST_RDATA) begin
                        shreg_q  <= rd_data;
                        bitcnt_q <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (byte_full) bitcnt_q <= '0;
                        else           shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= !sda_s;
                    end else if (scl_fall && mack_q) begin
                        shreg_q  <= rd_data;
                        bitcnt_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe      <= 1'b0;
            addr_load   <= 1'b0;
            addr_byte   <= '0;
            data_strobe <= 1'b0;
            data_byte   <= '0;
            commit      <= 1'b0;
            rd_next     <= 1'b0;
        end else begin
            addr_load   <= 1'b0;
            data_strobe <= 1'b0;
            commit      <= 1'b0;
            rd_next     <= 1'b0;
            if (busy) begin
                sda_oe <= 1'b0;
            end else begin
                sda_oe <= (state_q == ST_ACK) ||
                          (state_q == ST_RDATA && !shreg_q[BYTE_W-1]);
                commit <= stop_det && wrote_q && wr_grant;
                if (!start_det && !stop_det && scl_fall && byte_full) begin
                    if (state_q == ST_WORDADDR) begin
                        addr_load <= 1'b1;
                        addr_byte <= shreg_q;
                    end
                    if (state_q == ST_WDATA) begin
                        data_strobe <= 1'b1;
                        data_byte   <= shreg_q;
                    end
                end
                rd_next <= !start_det && !stop_det && scl_fall &&
                           ((state_q == ST_ACK && ret_q == ST_RDATA) ||
                            (state_q == ST_RACK && mack_q));
            end
        end
    end

endmodule

// File: rtl/eeslv_checker.sv
module eeslv_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic addr_load,
    input logic data_strobe,
    input logic commit,
    input logic rd_next,
    input logic busy
);

    // R11: nothing is driven while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r11: assert (!sda_oe && !busy && !commit);
        end
    end

    // R8: SDA drive only changes while the bus clock is low
    p_sda_change_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    // R7: no acknowledge while programming
    p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R7: no strobes while programming
    p_no_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(addr_load || data_strobe || rd_next));

    // R7: a commit opens the busy interval
    p_commit_starts_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R6: commit is a single-cycle pulse
    p_commit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R5: the strobes never coincide
    p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load, data_strobe, commit, rd_next}));

endmodule

bind eeslv_engine eeslv_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_in),
    .sda_oe      (sda_oe),
    .addr_load   (addr_load),
    .data_strobe (data_strobe),
    .commit      (commit),
    .rd_next     (rd_next),
    .busy        (busy)
);

// File: tb/eeslv_engine_test.sv
`timescale 1ns/1ps
module eeslv_engine_test;

    localparam int BUSY = 600;
    localparam int T    = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wr_grant = 1'b1;
    logic [7:0] rd_data;
    logic       sda_oe, addr_load, data_strobe, commit, rd_next, prot_cmd, busy;
    logic [7:0] addr_byte, data_byte;
    logic       sda_line;

    int         n_chk = 0;
    int         n_fail = 0;
    int         rd_cnt = 0;
    bit         done = 1'b0;
    logic [9:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = 8'hA0 + 8'(rd_cnt);

    eeslv_engine #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .strap(strap), .wr_grant(wr_grant), .rd_data(rd_data),
        .sda_oe(sda_oe), .addr_load(addr_load), .addr_byte(addr_byte),
        .data_strobe(data_strobe), .data_byte(data_byte), .commit(commit),
        .rd_next(rd_next), .prot_cmd(prot_cmd), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected strobes (kind 1 addr, 2 data, 3 commit)
    task automatic pop_cmp(input logic [1:0] kind, input logic [7:0] val);
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected strobe", {kind, val}, 0);
        end else begin
            e = exp_q.pop_front();
            check(e == {kind, val}, "R4/R5/R6 strobe", {kind, val}, e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_load)   pop_cmp(2'd1, addr_byte);
            if (data_strobe) pop_cmp(2'd2, data_byte);
            if (commit)      pop_cmp(2'd3, 8'h00);
            if (rd_next)     rd_cnt++;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; w(T); scl_m = 1'b1; w(T); sda_m = 1'b0; w(T); scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; w(T); scl_m = 1'b1; w(T); sda_m = 1'b1; w(T);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = v[i]; w(T); scl_m = 1'b1; w(T); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        send_bits(v, 8);
        sda_m = 1'b1; w(T); scl_m = 1'b1; w(T/2);
        acked = (sda_line == 1'b0);
        w(T/2); scl_m = 1'b0;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; w(T); scl_m = 1'b1; w(T/2);
            v[i] = sda_line;
            w(T/2); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; w(T); scl_m = 1'b1; w(T); scl_m = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] rb;
        w(5);
        check(!sda_oe && !busy && !commit && !prot_cmd, "R11 reset outputs", sda_oe, 0);
        rst_n = 1'b1;
        w(10);
        check(!sda_oe && !addr_load && !data_strobe, "R11 after reset", sda_oe, 0);

        // single byte write
        exp_q.push_back({2'd1, 8'h35});
        exp_q.push_back({2'd2, 8'h5A});
        exp_q.push_back({2'd3, 8'h00});
        bus_start;
        send_byte(8'hAA, a); check(a, "R2 write address ack", a, 1);
        send_byte(8'h35, a); check(a, "R4 word address ack", a, 1);
        send_byte(8'h5A, a); check(a, "R5 data ack", a, 1);
        bus_stop;
        check(busy, "R6 commit raised busy", busy, 1);

        // poll during programming
        bus_start;
        send_byte(8'hAA, a); check(!a, "R7 no ack while busy", a, 0);
        bus_stop;
        w(BUSY + 100);
        bus_start;
        send_byte(8'hAA, a); check(a, "R7 ack after interval", a, 1);
        bus_stop;
        check(!busy, "R6 no commit without data", busy, 0);

        // multi-byte write
        exp_q.push_back({2'd1, 8'h10});
        exp_q.push_back({2'd2, 8'h11});
        exp_q.push_back({2'd2, 8'h22});
        exp_q.push_back({2'd2, 8'h33});
        exp_q.push_back({2'd3, 8'h00});
        bus_start;
        send_byte(8'hAA, a);
        check(!prot_cmd, "R10 memory family", prot_cmd, 0);
        send_byte(8'h10, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a); check(a, "R5 last data ack", a, 1);
        bus_stop;
        w(BUSY + 100);

        // grant withheld
        wr_grant = 1'b0;
        exp_q.push_back({2'd1, 8'h20});
        exp_q.push_back({2'd2, 8'h77});
        bus_start;
        send_byte(8'hAA, a);
        send_byte(8'h20, a);
        send_byte(8'h77, a);
        bus_stop;
        check(!busy, "R6 no commit without grant", busy, 0);
        bus_start;
        send_byte(8'hAA, a); check(a, "R6 ack with no interval", a, 1);
        bus_stop;
        wr_grant = 1'b1;

        // address mismatch: wrong strap, then wrong family
        bus_start;
        send_byte(8'hA0, a); check(!a, "R3 wrong strap nack", a, 0);
        send_byte(8'h55, a); check(!a, "R3 ignored byte nack", a, 0);
        bus_stop;
        bus_start;
        send_byte(8'hBA, a); check(!a, "R3 wrong family nack", a, 0);
        bus_stop;

        // start inside a byte aborts it
        exp_q.push_back({2'd1, 8'h44});
        exp_q.push_back({2'd2, 8'h99});
        exp_q.push_back({2'd3, 8'h00});
        bus_start;
        send_byte(8'hAA, a);
        send_bits(8'hF0, 3);
        bus_start;
        send_byte(8'hAA, a); check(a, "R9 address after abort", a, 1);
        send_byte(8'h44, a);
        send_byte(8'h99, a); check(a, "R9 data after abort", a, 1);
        bus_stop;
        w(BUSY + 100);

        // read two bytes
        exp_q.push_back({2'd1, 8'h40});
        bus_start;
        send_byte(8'hAA, a);
        send_byte(8'h40, a);
        bus_start;
        send_byte(8'hAB, a); check(a, "R2 read address ack", a, 1);
        read_byte(1'b1, rb); check(rb == 8'hA0, "R8 first read byte", rb, 8'hA0);
        read_byte(1'b0, rb); check(rb == 8'hA1, "R8 second read byte", rb, 8'hA1);
        w(5);
        check(!sda_oe, "R8 released after nack", sda_oe, 0);
        bus_stop;
        check(!sda_oe && !busy, "R1 idle after stop", sda_oe, 0);

        // protection family
        bus_start;
        send_byte(8'h6A, a); check(a, "R2 protection address ack", a, 1);
        check(prot_cmd, "R10 protection flag", prot_cmd, 1);
        bus_stop;
        check(!prot_cmd, "R10 cleared by stop", prot_cmd, 0);

        w(20);
        check(exp_q.size() == 0, "R5 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule